// File: doc/BRIEF.md
# Split-Aware Bus Arbiter

This block decides which of several bus masters owns a shared AHB-style bus. It also keeps track of masters that a slave has parked with a SPLIT response. When a transfer ends in SPLIT, the arbiter marks the master that owned it as parked. A parked master takes no part in arbitration, whatever its request line shows. The mark stays until the slave raises that master's bit on a resume vector, which tells the arbiter it can now serve the master. RETRY, ERROR and OKAY responses never park anyone, so a master that was told to retry can ask for the bus again at once.

Ownership rotates round-robin among requesters that are not parked. The search starts just after the master that holds the grant. Grants move only on a clock edge where HREADY is high, so a transfer in its wait states keeps the bus. If no master can be granted, either because none requests or because every requester is parked, the grant falls to master 0. One master always drives the bus, and the arbiter cannot deadlock when every master is waiting on a split slave. The arbiter also outputs the number of the current master: this is the granted index registered one HREADY-high edge later, so it follows the address phase of the new owner.

Top module: `bus_split_arbiter`

## Requirements
- R1: During and right after reset, `grant_o` is 4'b0001 (master 0), `owner_o` is 0, and no master is parked.
- R2: Exactly one bit of `grant_o` is set at all times.
- R3: `grant_o` and `owner_o` change only on a rising edge where `hready_i` is 1. On an edge where `hready_i` is 0, both keep their values.
- R4: On an edge where `hready_i` is 1, the grant moves to the first eligible requester, searching upward from the index after the current grant and wrapping. Eligible means `req_i` is 1 and the master is not parked. Example: current grant 1, eligible 4'b1010, new grant 3.
- R5: A SPLIT response is `hresp_i` = 2'b11 on an edge where `hready_i` is 1. It parks the master numbered `owner_o`. That master is left out of the arbitration on that same edge and on every later edge until it is resumed.
- R6: If bit n of `resume_i` is 1 on an edge, master n is no longer parked after that edge. Master n can already be granted on that same edge.
- R7: `hresp_i` values 2'b00 (OKAY), 2'b01 (ERROR) and 2'b10 (RETRY) never park a master. Neither does 2'b11 on an edge where `hready_i` is 0.
- R8: On an edge where `hready_i` is 1 and no eligible master requests, the grant goes to master 0. This includes the case where every requester is parked.
- R9: Several masters can be parked at once. Resuming one of them leaves the others parked.
- R10: On each edge where `hready_i` is 1, `owner_o` takes the index of the master that was granted just before that edge.
- R11: If the same edge brings a SPLIT for master n and bit n of `resume_i`, the SPLIT wins and master n stays parked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Bus request, one bit per master |
| hready_i | input | 1 | Transfer-done flag from the selected slave |
| hresp_i | input | 2 | Slave response: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| resume_i | input | 4 | Per-master resume pulses from split-capable slaves |
| grant_o | output | 4 | One-hot bus grant |
| owner_o | output | 2 | Number of the master whose address phase is on the bus |

## Verification
The rotation is driven with all four masters requesting and with a sparse pattern. These two separate a true round-robin search from fixed priority and from a search that starts at the wrong index. The split path uses the realistic two-cycle response, with HREADY low and then high. This shows that only the second cycle parks the master, and that RETRY and ERROR leave it eligible. Parking three masters one after another while they all keep requesting shows the default fallback. Resuming them one at a time shows that each mark is held on its own. A final case puts a SPLIT and a resume for the same master on the same edge to fix which one wins.

// File: rtl/bus_split_arbiter_pkg.sv
package bus_split_arbiter_pkg;
   typedef enum logic [1:0] {
      RESP_OKAY  = 2'b00,
      RESP_ERROR = 2'b01,
      RESP_RETRY = 2'b10,
      RESP_SPLIT = 2'b11
   } resp_e;
endpackage

// File: rtl/split_park_reg.sv
// Holds one "parked" flag per master. A set wins over a clear in the same cycle.
module split_park_reg #(
   parameter int N_MASTERS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] set_i,
   input  logic [N_MASTERS-1:0] clr_i,
   output logic [N_MASTERS-1:0] park_d,
   output logic [N_MASTERS-1:0] park_q
);
   always_comb park_d = (park_q & ~clr_i) | set_i;

   always_ff @(posedge clk) begin
      if (!rst_n) park_q <= '0;
      else        park_q <= park_d;
   end

   // A set only happens on a SPLIT. Anything else can only clear flags.
   AST_NO_SPURIOUS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0) |=> ((park_q & ~$past(park_q)) == '0)); // R7

   for (genvar n = 0; n < N_MASTERS; n++) begin : g_chk
      AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[n] && !set_i[n]) |=> !park_q[n]); // R6
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[n] |=> park_q[n]); // R11
   end
endmodule

// File: rtl/rr_pick.sv
// Picks the first eligible master after the current one, wrapping around.
module rr_pick #(
   parameter int N_MASTERS = 4,
   localparam int IDXW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
   input  logic [N_MASTERS-1:0] elig_i,
   input  logic [IDXW-1:0]      cur_i,
   output logic                 found_o,
   output logic [IDXW-1:0]      pick_o
);
   int cand;

   always_comb begin
      found_o = 1'b0;
      pick_o  = '0;
      cand    = 0;
      for (int i = 1; i <= N_MASTERS; i++) begin
         cand = int'(cur_i) + i;
         if (cand >= N_MASTERS) cand = cand - N_MASTERS;
         if (!found_o && elig_i[cand]) begin
            found_o = 1'b1;
            pick_o  = IDXW'(cand);
         end
      end
   end

   always_comb begin
      if (found_o) AST_PICK_ELIGIBLE: assert (elig_i[pick_o]); // R4
      else         AST_NONE_ELIGIBLE: assert (elig_i == '0);   // R8
   end
endmodule

// File: rtl/bus_split_arbiter.sv
module bus_split_arbiter
   import bus_split_arbiter_pkg::*;
#(
   parameter int N_MASTERS      = 4,
   parameter int DEFAULT_MASTER = 0,
   localparam int IDXW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_i,
   input  logic                 hready_i,
   input  logic [1:0]           hresp_i,
   input  logic [N_MASTERS-1:0] resume_i,
   output logic [N_MASTERS-1:0] grant_o,
   output logic [IDXW-1:0]      owner_o
);
   localparam logic [N_MASTERS-1:0] DEF_OH  = N_MASTERS'(1) << DEFAULT_MASTER;
   localparam logic [IDXW-1:0]      DEF_IDX = IDXW'(DEFAULT_MASTER);

   if (N_MASTERS < 2 || N_MASTERS > 16) begin : g_bad_n
      $error("N_MASTERS must lie between 2 and 16");
   end
   if (DEFAULT_MASTER < 0 || DEFAULT_MASTER >= N_MASTERS) begin : g_bad_def
      $error("DEFAULT_MASTER must name an existing master");
   end

   logic                 split_hit;
   logic [N_MASTERS-1:0] park_set, park_d, park_q, elig;
   logic [IDXW-1:0]      cur_idx, pick_idx;
   logic                 pick_found;

   function automatic logic [IDXW-1:0] oh2idx(input logic [N_MASTERS-1:0] oh);
      logic [IDXW-1:0] r;
      r = '0;
      for (int i = 0; i < N_MASTERS; i++)
         if (oh[i]) r = IDXW'(i);
      return r;
   endfunction

   always_comb begin
      split_hit = hready_i && (resp_e'(hresp_i) == RESP_SPLIT);
      park_set  = split_hit ? (N_MASTERS'(1) << owner_o) : '0;
      elig      = req_i & ~park_d;
      cur_idx   = oh2idx(grant_o);
   end

   split_park_reg #(.N_MASTERS(N_MASTERS)) u_park (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (park_set),
      .clr_i  (resume_i),
      .park_d (park_d),
      .park_q (park_q)
   );

   rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
      .elig_i  (elig),
      .cur_i   (cur_idx),
      .found_o (pick_found),
      .pick_o  (pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_o <= DEF_OH;
         owner_o <= DEF_IDX;
      end else if (hready_i) begin
         grant_o <= pick_found ? (N_MASTERS'(1) << pick_idx) : DEF_OH;
         owner_o <= cur_idx;
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant_o) == 1); // R2
   AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      !hready_i |=> ($stable(grant_o) && $stable(owner_o))); // R3
   AST_PARKED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      hready_i |=> (((grant_o & $past(elig)) != '0) ||
                    (($past(elig) == '0) && (grant_o == DEF_OH)))); // R5
   AST_SPLIT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      split_hit |=> park_q[$past(owner_o)]); // R5
   AST_OWNER_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      hready_i |=> (grant_o == grant_o) && (owner_o == oh2idx($past(grant_o)))); // R10
endmodule

// File: tb/bus_split_arbiter_test.sv
module bus_split_arbiter_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] req;
   logic       hready;
   logic [1:0] hresp;
   logic [3:0] resume;
   logic [3:0] grant;
   logic [1:0] owner;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   bus_split_arbiter uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req),
      .hready_i (hready),
      .hresp_i  (hresp),
      .resume_i (resume),
      .grant_o  (grant),
      .owner_o  (owner)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic unpark_all();
      req = 4'b0000; hready = 1'b1; hresp = 2'b00; resume = 4'b1111;
      step();
      resume = 4'b0000;
      step();
   endtask

   // Hand the bus to master m and let owner_o catch up.
   task automatic own(input int m);
      req = 4'b0001 << m; hready = 1'b1; hresp = 2'b00;
      step();
      step();
   endtask

   task automatic t_reset();
      rst_n = 1'b0; req = 4'b0000; hready = 1'b1; hresp = 2'b00; resume = 4'b0000;
      step();
      step();
      chk("R1 grant in reset", 8'(grant), 8'h1);
      chk("R1 owner in reset", 8'(owner), 8'h0);
      rst_n = 1'b1;
      req = 4'b0001;
      step();
      chk("R1 master 0 not parked after reset", 8'(grant), 8'h1);
   endtask

   task automatic t_rotate();
      logic [3:0] prev;
      req = 4'b1111; hready = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         prev = grant;
         step();
         chk("R4 full rotation", 8'(grant), 8'(4'b0001 << (k % 4)));
         chk("R2 one grant", 8'($countones(grant)), 8'h1);
         chk("R10 owner follows grant", 8'(owner), 8'($clog2(prev)));
      end
      // Now at master 1; sparse requests 1010 alternate between 3 and 1.
      req = 4'b1010;
      step();
      chk("R4 sparse next", 8'(grant), 8'h8);
      step();
      chk("R4 sparse wrap", 8'(grant), 8'h2);
   endtask

   task automatic t_wait();
      logic [3:0] g;
      logic [1:0] o;
      req = 4'b1111; hready = 1'b1;
      step();
      g = grant; o = owner;
      hready = 1'b0; req = 4'b0100;
      step();
      step();
      chk("R3 grant held in wait", 8'(grant), 8'(g));
      chk("R3 owner held in wait", 8'(owner), 8'(o));
      hready = 1'b1;
      step();
      chk("R3 grant moves on ready", 8'(grant), 8'h4);
   endtask

   task automatic t_split();
      unpark_all();
      own(2);
      chk("R10 owner is 2", 8'(owner), 8'h2);
      hready = 1'b0; hresp = 2'b11;
      step();
      chk("R7 first response cycle does not park", 8'(grant), 8'h4);
      hready = 1'b1;
      step();
      chk("R5 split master dropped", 8'(grant), 8'h1);
      hresp = 2'b00;
      step();
      step();
      chk("R5 split master stays out", 8'(grant), 8'h1);
      resume = 4'b0100;
      step();
      chk("R6 resume regrants same edge", 8'(grant), 8'h4);
      resume = 4'b0000;
   endtask

   task automatic t_nonsplit();
      unpark_all();
      own(2);
      hresp = 2'b10;
      step();
      chk("R7 retry keeps master", 8'(grant), 8'h4);
      hresp = 2'b01;
      step();
      chk("R7 error keeps master", 8'(grant), 8'h4);
      hresp = 2'b00;
      step();
      chk("R7 okay keeps master", 8'(grant), 8'h4);
   endtask

   task automatic t_all_parked();
      unpark_all();
      for (int m = 1; m <= 3; m++) begin
         own(m);
         hresp = 2'b11;
         step();
         hresp = 2'b00;
      end
      req = 4'b1110;
      step();
      chk("R8 all requesters parked -> default", 8'(grant), 8'h1);
      req = 4'b0000;
      step();
      chk("R8 no request -> default", 8'(grant), 8'h1);
      req = 4'b1110; resume = 4'b0010;
      step();
      chk("R9 resumed master granted", 8'(grant), 8'h2);
      resume = 4'b0000;
      step();
      chk("R9 others remain parked", 8'(grant), 8'h2);
      resume = 4'b1000;
      step();
      chk("R9 second resume", 8'(grant), 8'h8);
      resume = 4'b0000; req = 4'b0100;
      step();
      chk("R9 master 2 still parked", 8'(grant), 8'h1);
   endtask

   task automatic t_collide();
      unpark_all();
      own(2);
      hresp = 2'b11; resume = 4'b0100;
      step();
      chk("R11 split beats resume", 8'(grant), 8'h1);
      hresp = 2'b00; resume = 4'b0000;
      step();
      chk("R11 master stays parked", 8'(grant), 8'h1);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_rotate();
      t_wait();
      t_split();
      t_nonsplit();
      t_all_parked();
      t_collide();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule